// File: doc/BRIEF.md
# NCO Nanosecond Time-of-Day Counter

This block keeps a free-running nanosecond time for a packet timestamping clock. A numerically controlled accumulator adds a programmable fixed-point increment on every reference clock cycle. The increment has 28 fractional bits below the nanosecond LSB. The integer part of the accumulator is a 44-bit nanosecond time, which wraps to zero after 2^44 ns (about 4.89 hours). The live time is also driven on a parallel output for timestamp logic elsewhere in the chip.

Software reaches the block through four 32-bit word registers, selected by a 2-bit word index:

| Index | Register |
|---|---|
| 0 | Fine time nibble |
| 1 | Middle 32-bit time word |
| 2 | Top time byte |
| 3 | Increment |

Loading a new time takes three writes: the fine nibble, then the middle word, then the top byte. Nothing reaches the counter until the last of these writes, which commits the full time in a single edge. Reading the top byte captures a snapshot of the middle word, so a following read of the middle word belongs to the same instant. Software trims the frequency by moving the increment around its nominal value, and it stops the clock by writing zero.

Top module: `nco_tod_timer`

## Requirements
- R1: After reset the time output is 0 and the increment reads 0. The time then stays at 0 until a nonzero increment is written.
- R2: The increment is an unsigned 32-bit value in units of 2^-28 ns. Each cycle adds it to the time together with a hidden 28-bit fraction, so 0x80000000 advances the time by exactly 8 ns per cycle and 0x08000000 advances it by 1 ns every second cycle.
- R3: While the increment is zero and no load occurs, the time does not change.
- R4: A write to index 0 stages wdata[3:0] as the fine nibble, and a write to index 1 stages wdata[31:0] as the middle word. A write to index 2 loads the time {wdata[15:8], staged middle, staged fine} and clears the fraction. wdata[7:0] of that write is ignored.
- R5: Staging writes to index 0 and index 1 leave the time output unchanged. The new time appears only on the edge of the index 2 write.
- R6: The time wraps modulo 2^44: 0xFFFFFFFFFFC plus 8 ns gives 0x00000000004.
- R7: A read of index 2 returns time[43:36] in rdata[7:0] with zeros above. On the same edge it captures time[35:4] as a snapshot.
- R8: A read of index 1 returns the snapshot taken at the most recent index 2 read, even if the time has advanced since.
- R9: A read of index 0 returns the live time[3:0] in rdata[3:0], with zeros above. A read of index 3 returns the current increment.
- R10: Read data is registered and appears on the first clock edge after rd_en_i. It holds its value while no read is issued.
- R11: Trimmed increments of 0x80000000 ± 0x6666666 correspond to ±50,000,000 ppb. The time advances by exactly floor(N·increment / 2^28) ns over N cycles after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| idx_i | input | 2 | Register word index (0 fine, 1 middle, 2 top, 3 increment) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| time_o | output | 44 | Live 44-bit nanosecond time |

## Verification
The time output shows any fault in the accumulator at once: a wrong carry out of the fraction or a wrong wrap shows on the first edge after a load, and a fractional error shows within a few tens of cycles. A staging register that leaks into the counter shows on the same edge as the stray write, because the time changes while the increment is held at zero. A stale or misplaced snapshot shows only on a later read of the middle word. For that reason the bench separates the two reads by several cycles while the time is running, so that live and snapshot values differ.

// File: rtl/nco_tod_pkg.sv
package nco_tod_pkg;
  localparam int unsigned NS_W_D   = 44;
  localparam int unsigned FRAC_W_D = 28;
  localparam int unsigned DATA_W_D = 32;
  localparam int unsigned FINE_W_D = 4;
  localparam int unsigned TOP_WR_LSB_D = 8;

  typedef enum logic [1:0] {
    REG_FINE = 2'd0,
    REG_MID  = 2'd1,
    REG_TOP  = 2'd2,
    REG_INC  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/nco_tod_accum.sv
module nco_tod_accum #(
  parameter int unsigned NS_W   = 44,
  parameter int unsigned FRAC_W = 28,
  parameter int unsigned INC_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              load_i,
  input  logic [NS_W-1:0]   load_ns_i,
  output logic [NS_W-1:0]   ns_o
);
  localparam int unsigned ACC_W = NS_W + FRAC_W;

  logic [ACC_W-1:0] acc_q;

  // Modulo 2^ACC_W sum gives the 2^44 ns wrap for free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= {load_ns_i, {FRAC_W{1'b0}}};
    else             acc_q <= acc_q + ACC_W'(inc_i);
  end

  assign ns_o = acc_q[ACC_W-1:FRAC_W];

  AST_LOAD_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ns_o == $past(load_ns_i)); // R4

  AST_HALT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && inc_i == '0) |=> $stable(ns_o)); // R3

  AST_STEP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> NS_W'(ns_o - $past(ns_o)) <= NS_W'($past(inc_i) >> FRAC_W) + NS_W'(1)); // R2
endmodule

// File: rtl/nco_tod_regs.sv
module nco_tod_regs import nco_tod_pkg::*; #(
  parameter int unsigned NS_W       = 44,
  parameter int unsigned FINE_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned TOP_WR_LSB = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NS_W-1:0]   ns_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] inc_o,
  output logic              load_o,
  output logic [NS_W-1:0]   load_ns_o
);
  localparam int unsigned MID_W = DATA_W;
  localparam int unsigned TOP_W = NS_W - FINE_W - MID_W;

  logic [FINE_W-1:0] fine_stg_q;
  logic [MID_W-1:0]  mid_stg_q;
  logic [MID_W-1:0]  snap_mid_q;
  logic [DATA_W-1:0] inc_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_fine, wr_mid, wr_inc, rd_top;

  assign wr_fine = wr_en_i && (idx_i == REG_FINE);
  assign wr_mid  = wr_en_i && (idx_i == REG_MID);
  assign wr_inc  = wr_en_i && (idx_i == REG_INC);
  assign load_o  = wr_en_i && (idx_i == REG_TOP);
  assign rd_top  = rd_en_i && (idx_i == REG_TOP);

  // Top byte rides in the second byte lane on writes
  assign load_ns_o = {wdata_i[TOP_WR_LSB +: TOP_W], mid_stg_q, fine_stg_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_stg_q <= '0;
      mid_stg_q  <= '0;
      inc_q      <= '0;
    end else begin
      if (wr_fine) fine_stg_q <= wdata_i[FINE_W-1:0];
      if (wr_mid)  mid_stg_q  <= wdata_i[MID_W-1:0];
      if (wr_inc)  inc_q      <= wdata_i;
    end
  end

  always_comb begin
    unique case (idx_i)
      REG_FINE: rd_mux = DATA_W'(ns_i[FINE_W-1:0]);
      REG_MID:  rd_mux = snap_mid_q;
      REG_TOP:  rd_mux = DATA_W'(ns_i[NS_W-1 -: TOP_W]);
      default:  rd_mux = inc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_mid_q <= '0;
      rdata_q    <= '0;
    end else begin
      if (rd_top)  snap_mid_q <= ns_i[FINE_W +: MID_W];
      if (rd_en_i) rdata_q    <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign inc_o   = inc_q;

  AST_TOP_ZERO_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_top |=> rdata_o[DATA_W-1:TOP_W] == '0); // R7

  AST_INC_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_inc |=> $stable(inc_o)); // R3

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/nco_tod_timer.sv
module nco_tod_timer import nco_tod_pkg::*; #(
  parameter int unsigned NS_W       = NS_W_D,
  parameter int unsigned FRAC_W     = FRAC_W_D,
  parameter int unsigned DATA_W     = DATA_W_D,
  parameter int unsigned FINE_W     = FINE_W_D,
  parameter int unsigned TOP_WR_LSB = TOP_WR_LSB_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NS_W-1:0]   time_o
);
  logic [DATA_W-1:0] inc;
  logic              load;
  logic [NS_W-1:0]   load_ns;
  logic [NS_W-1:0]   ns;

  nco_tod_regs #(
    .NS_W(NS_W), .FINE_W(FINE_W), .DATA_W(DATA_W), .TOP_WR_LSB(TOP_WR_LSB)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .idx_i(idx_i), .wdata_i(wdata_i), .ns_i(ns), .rdata_o(rdata_o),
    .inc_o(inc), .load_o(load), .load_ns_o(load_ns)
  );

  nco_tod_accum #(
    .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(DATA_W)
  ) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc), .load_i(load),
    .load_ns_i(load_ns), .ns_o(ns)
  );

  assign time_o = ns;
endmodule

// File: tb/sim_nco_tod_timer.sv
module sim_nco_tod_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  idx = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [43:0] tod;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_tod_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .idx_i(idx), .wdata_i(wdata), .rdata_o(rdata), .time_o(tod)
  );

  always @(posedge clk) rd_seen <= rd_en;

  // Monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s rdata act=%h exp=%h", t, rdata, e);
      end
    end
  end

  task automatic chk_time(input logic [43:0] e, input string t);
    checks++;
    if (tod !== e) begin
      fails++;
      $display("FAIL %s time act=%h exp=%h", t, tod, e);
    end
  endtask

  task automatic wr(input logic [1:0] i, input logic [31:0] d);
    wr_en = 1'b1; idx = i; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] i, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; idx = i;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load(input logic [43:0] v);
    wr(2'd3, 32'h0);
    wr(2'd0, {28'h0, v[3:0]});
    wr(2'd1, v[35:4]);
    wr(2'd2, {16'h0, v[43:36], 8'h00});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [43:0] t;
    logic [31:0] inc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and halt
    chk_time(44'h0, "R1 reset");
    rd(2'd3, 32'h0, "R1 inc reset");
    repeat (5) @(negedge clk);
    chk_time(44'h0, "R1 halted");

    // R4/R5 staged load, low byte lane ignored on top write
    wr(2'd0, 32'hFFFF_FFF5);
    chk_time(44'h0, "R5 fine staged");
    wr(2'd1, 32'h1234_5678);
    chk_time(44'h0, "R5 mid staged");
    wr(2'd2, 32'h0000_ABFF);
    chk_time(44'hAB1_2345_6785, "R4 commit");
    repeat (4) @(negedge clk);
    chk_time(44'hAB1_2345_6785, "R3 frozen");

    // R7/R8/R9 readback, frozen time
    rd(2'd2, 32'h0000_00AB, "R7 top");
    rd(2'd1, 32'h1234_5678, "R8 mid");
    rd(2'd0, 32'h0000_0005, "R9 fine");
    rd(2'd3, 32'h0, "R9 inc");

    // R2 nominal 8 ns per cycle
    wr(2'd3, 32'h8000_0000);
    chk_time(44'hAB1_2345_6785, "R2 inc latency");
    repeat (10) @(negedge clk);
    chk_time(44'hAB1_2345_6785 + 44'd80, "R2 nominal rate");
    rd(2'd3, 32'h8000_0000, "R9 inc readback");

    // R7/R8 coherent read while running
    t = tod;
    rd(2'd2, {24'h0, t[43:36]}, "R7 top live");
    repeat (6) @(negedge clk);
    rd(2'd1, t[35:4], "R8 snapshot coherent");
    t = tod;
    rd(2'd0, {28'h0, t[3:0]}, "R9 fine live");

    // R10 hold without read
    repeat (3) @(negedge clk);
    checks++;
    if (rdata !== {28'h0, t[3:0]}) begin
      fails++;
      $display("FAIL R10 hold act=%h exp=%h", rdata, {28'h0, t[3:0]});
    end

    // R2 fractional increment 0.5 ns
    load(44'h0);
    wr(2'd3, 32'h0800_0000);
    repeat (10) @(negedge clk);
    chk_time(44'd5, "R2 half ns x10");
    @(negedge clk);
    chk_time(44'd5, "R2 half ns x11");
    @(negedge clk);
    chk_time(44'd6, "R2 half ns x12");

    // R3 stop by zero increment
    wr(2'd3, 32'h0);
    t = tod;
    repeat (5) @(negedge clk);
    chk_time(t, "R3 stopped");

    // R6 wrap
    load(44'hFFF_FFFF_FFFC);
    wr(2'd3, 32'h8000_0000);
    chk_time(44'hFFF_FFFF_FFFC, "R6 before wrap");
    @(negedge clk);
    chk_time(44'h000_0000_0004, "R6 wrapped");

    // R11 trims at +/-50e6 ppb
    for (int s = 0; s < 2; s++) begin
      inc = (s == 0) ? 32'h8000_0000 + 32'h0666_6666 : 32'h8000_0000 - 32'h0666_6666;
      load(44'h0);
      wr(2'd3, inc);
      repeat (25) @(negedge clk);
      chk_time(44'((64'(inc) * 64'd25) >> 28), s == 0 ? "R11 trim up" : "R11 trim down");
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule